// File: doc/BRIEF.md
# Status Flag Register and Branch Condition Evaluator

This block keeps the four processor status flags (negative, zero, overflow and carry) and decides whether a conditional branch is taken. On every clock edge each flag can be loaded from the current ALU outcome or left unchanged. Each flag has its own write enable. This lets an arithmetic operation, a compare or test, or a shift that touches only the carry update exactly the flags it owns.

A purely combinational evaluator reads a 4-bit condition code together with the registered flags and drives a taken signal. A branch presented in the same cycle as a flag write sees the flags as they stood before that edge.

Top module: `cond_flags_unit`

## Requirements
- R1: While reset is asserted (rst_n low), all four flags read 0.
- R2: A flag whose write enable is low at a clock edge keeps its previous value. Each flag's enable acts independently of the other three.
- R3: When wr_z is high at an edge, flag_z becomes 1 if every bit of alu_result is 0, and 0 otherwise.
- R4: When wr_n is high at an edge, flag_n becomes the most significant bit of alu_result.
- R5: When wr_c or wr_v is high at an edge, flag_c takes alu_carry or flag_v takes alu_ovf respectively.
- R6: taken is computed from the flags currently held. A flag write in the same cycle affects taken only from the following cycle.
- R7: Condition code 0 is always taken. Code 1 is never taken.
- R8: Codes 2/3 are taken on Z set/clear. Codes 4/5 are taken on C set/clear. Codes 6/7 are taken on N set/clear. Codes 8/9 are taken on V set/clear.
- R9: The signed relations are as follows. Code 10 (less) is taken when N xor V. Code 11 (greater or equal) is its inverse. Code 12 (less or equal) is taken when Z or (N xor V). Code 13 (greater) is the inverse of code 12.
- R10: The unsigned relations are as follows. Code 14 (lower or same) is taken when C or Z. Code 15 (higher) is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_result | input | DATA_W | ALU result word |
| alu_carry | input | 1 | ALU carry out |
| alu_ovf | input | 1 | ALU signed overflow |
| wr_n | input | 1 | Write enable for the negative flag |
| wr_z | input | 1 | Write enable for the zero flag |
| wr_v | input | 1 | Write enable for the overflow flag |
| wr_c | input | 1 | Write enable for the carry flag |
| cond | input | 4 | Branch condition code |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| taken | output | 1 | Branch condition satisfied |

## Verification
A flag update and a branch decision can fall in the same cycle. The hazard is that the decision might see the incoming flags instead of the held ones.

The bench provokes this on almost every cycle. It drives random write enables, a random result biased toward zero, and a random condition code together.

It judges taken just before the edge against a reference model's flags from the previous edge. The model is updated only after that edge, so a design that forwarded new flags into taken would be reported.

// File: rtl/cond_flags_unit.sv
module cond_flags_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              wr_n,
  input  logic              wr_z,
  input  logic              wr_v,
  input  logic              wr_c,
  input  logic [3:0]        cond,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              taken
);
  localparam int MSB = DATA_W - 1;

  logic res_zero, res_neg, lt_s, le_s, le_u;

  assign res_zero = ~|alu_result;
  assign res_neg  = alu_result[MSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      if (wr_n) flag_n <= res_neg;
      if (wr_z) flag_z <= res_zero;
      if (wr_v) flag_v <= alu_ovf;
      if (wr_c) flag_c <= alu_carry;
    end
  end

  assign lt_s = flag_n ^ flag_v;
  assign le_s = flag_z | lt_s;
  assign le_u = flag_c | flag_z;

  always_comb begin
    unique case (cond)
      4'd0:  taken = 1'b1;
      4'd1:  taken = 1'b0;
      4'd2:  taken = flag_z;
      4'd3:  taken = ~flag_z;
      4'd4:  taken = flag_c;
      4'd5:  taken = ~flag_c;
      4'd6:  taken = flag_n;
      4'd7:  taken = ~flag_n;
      4'd8:  taken = flag_v;
      4'd9:  taken = ~flag_v;
      4'd10: taken = lt_s;
      4'd11: taken = ~lt_s;
      4'd12: taken = le_s;
      4'd13: taken = ~le_s;
      4'd14: taken = le_u;
      default: taken = ~le_u;
    endcase
  end
endmodule

// File: rtl/cond_flags_unit_chk.sv
module cond_flags_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] alu_result,
  input logic              alu_carry,
  input logic              alu_ovf,
  input logic              wr_n,
  input logic              wr_z,
  input logic              wr_v,
  input logic              wr_c,
  input logic [3:0]        cond,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c,
  input logic              taken
);
  a_r2_hold_n: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |=> $stable(flag_n));
  a_r2_hold_c: assert property (@(posedge clk) disable iff (!rst_n) !wr_c |=> $stable(flag_c));
  a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_z |=> flag_z == ($past(alu_result) == '0));
  a_r4_neg: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> flag_n == $past(alu_result[DATA_W-1]));
  a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c |=> flag_c == $past(alu_carry));
  a_r5_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    wr_v |=> flag_v == $past(alu_ovf));
  a_r7_always: assert property (@(posedge clk) disable iff (!rst_n) cond == 4'd0 |-> taken);
  a_r7_never: assert property (@(posedge clk) disable iff (!rst_n) cond == 4'd1 |-> !taken);
endmodule

bind cond_flags_unit cond_flags_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_carry(alu_carry),
  .alu_ovf(alu_ovf), .wr_n(wr_n), .wr_z(wr_z), .wr_v(wr_v), .wr_c(wr_c),
  .cond(cond), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
  .flag_c(flag_c), .taken(taken)
);

// File: tb/cond_flags_unit_tb_top.sv
module cond_flags_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] alu_result = '0;
  logic alu_carry = 1'b0, alu_ovf = 1'b0;
  logic wr_n = 1'b0, wr_z = 1'b0, wr_v = 1'b0, wr_c = 1'b0;
  logic [3:0] cond = 4'd0;
  logic flag_n, flag_z, flag_v, flag_c, taken;

  int checks = 0;
  int errors = 0;
  bit m_n, m_z, m_v, m_c;

  always #(CLK_P/2) clk = ~clk;

  cond_flags_unit #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .wr_n(wr_n), .wr_z(wr_z), .wr_v(wr_v), .wr_c(wr_c),
    .cond(cond), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c), .taken(taken)
  );

  function automatic bit ref_taken(input int c);
    case (c)
      0: return 1;  1: return 0;
      2: return m_z; 3: return !m_z;
      4: return m_c; 5: return !m_c;
      6: return m_n; 7: return !m_n;
      8: return m_v; 9: return !m_v;
      10: return m_n ^ m_v; 11: return !(m_n ^ m_v);
      12: return m_z | (m_n ^ m_v); 13: return !(m_z | (m_n ^ m_v));
      14: return m_c | m_z;
      default: return !(m_c | m_z);
    endcase
  endfunction

  function automatic string tag_of(input int c);
    if (c < 2) return "R7";
    if (c < 10) return "R8";
    if (c < 14) return "R9";
    return "R10";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3/R4/R5 (R6 timing) flags", {flag_n, flag_z, flag_v, flag_c}, {m_n, m_z, m_v, m_c});
    chk({tag_of(int'(cond)), " taken (R6 old flags)"}, taken, ref_taken(int'(cond)));
  endtask

  task automatic step(input logic [W-1:0] res, input bit cy, input bit ov,
                      input bit en_n, input bit en_z, input bit en_v, input bit en_c,
                      input logic [3:0] cc);
    @(negedge clk);
    alu_result = res; alu_carry = cy; alu_ovf = ov;
    wr_n = en_n; wr_z = en_z; wr_v = en_v; wr_c = en_c; cond = cc;
    #1 compare_all();
    @(posedge clk);
    if (en_n) m_n = res[W-1];
    if (en_z) m_z = (res == '0);
    if (en_v) m_v = ov;
    if (en_c) m_c = cy;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_n = 0; m_z = 0; m_v = 0; m_c = 0;
    #(CLK_P*2 + 1);
    chk("R1 reset flags", {flag_n, flag_z, flag_v, flag_c}, 0);
    @(negedge clk); rst_n = 1'b1;
    // R3/R4: all-ones then zero result, all enables
    step(32'hFFFF_FFFF, 1, 1, 1, 1, 1, 1, 4'd6);
    step(32'h0000_0000, 0, 0, 1, 1, 1, 1, 4'd6);
    // R3: single bit set gives Z clear
    step(32'h0001_0000, 1, 0, 1, 1, 1, 1, 4'd2);
    // R2: shift-like carry-only update, others held
    step(32'h8000_0000, 0, 1, 0, 0, 0, 1, 4'd2);
    step(32'h0, 0, 0, 0, 0, 0, 0, 4'd4);
    // R7..R10: sweep all codes over current flags
    for (int c = 0; c < 16; c++) step(32'h0, 0, 0, 0, 0, 0, 0, 4'(c));
    // R6: write and branch in same cycle
    step(32'h0, 1, 0, 1, 1, 1, 1, 4'd2);
    step(32'h5, 0, 0, 1, 1, 1, 1, 4'd2);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] r;
      r = ($urandom_range(0, 3) == 0) ? '0 : W'($urandom);
      step(r, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 4'($urandom));
    end
    // R1: reset mid-run clears flags
    step(32'h8000_0000, 1, 1, 1, 1, 1, 1, 4'd0);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 reset mid-run", {flag_n, flag_z, flag_v, flag_c}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule